// File: doc/BRIEF.md
# Accumulator ALU with condition flags

This block is the arithmetic and logic datapath that sits beside an 8-bit or 16-bit accumulator. On each request it combines an accumulator operand X with a second operand M under a 5-bit operation code and a width select. It produces a result R, a write-back qualifier, and the next values of four condition flags: negative (N), zero (Z), signed overflow (V) and carry (C). The datapath itself is combinational. A registered condition-code register holds the flags. It captures the computed next flags on a clock edge when the enable input is high, and its carry feeds the rotate operations.

The flags do not all follow one rule. Each operation class updates them in its own way. Add and subtract derive V and C from the sign bits of the operands and the result. Logic operations clear V and leave C alone. Shifts load C with the bit that leaves the word and raise V when the sign bit changes. Increment and decrement touch only Z. Dedicated commands set or clear C and V alone, or load all four flags from the X operand. In 8-bit mode bit 7 is the sign bit and the upper byte of the result is zero.

Top module: `acc_alu_ccr`

## Requirements
- R1: With wide_i=0 only x_i[7:0] and m_i[7:0] are used, r_o[15:8] is zero and bit 7 is the sign bit; with wide_i=1 bit 15 is the sign bit. For every operation that updates N and Z (codes 0-3, 6-14), N equals the sign bit of r_o and Z is 1 exactly when r_o is zero.
- R2: Code 0 (add) gives r_o = X+M modulo 2^width, wr_o=1, V = Xs·Ms·¬Rs + ¬Xs·¬Ms·Rs and C = Xs·Ms + Ms·¬Rs + ¬Rs·Xs, where s marks the sign bit.
- R3: Code 1 (subtract) gives r_o = X−M modulo 2^width, wr_o=1, V = Xs·¬Ms·¬Rs + ¬Xs·Ms·Rs and C = ¬Xs·Ms + Ms·Rs + Rs·¬Xs.
- R4: Code 2 (compare) sets the flags and r_o exactly as subtract does; code 3 (test) behaves as a subtract of zero (r_o = X, V=0, C=0). Both give wr_o=0.
- R5: Codes 4 (increment) and 5 (decrement) give r_o = X±1 modulo 2^width and wr_o=1. They update only Z; N, V and C keep the register values.
- R6: Codes 6 (AND), 7 (OR), 8 (XOR) and 9 (complement, all-ones minus X) give wr_o=1 and V=0, and leave C unchanged.
- R7: Codes 10 (shift left), 11 (arithmetic shift right, sign bit kept) and 12 (logical shift right, zero inserted) give wr_o=1 and load C with the bit shifted out. V is 1 exactly when the sign bit of r_o differs from the sign bit of X.
- R8: Code 13 (rotate left through carry) moves the register C into bit 0 and the old sign bit into C. Code 14 (rotate right through carry) moves the register C into the sign bit and the old bit 0 into C. V follows R7 and wr_o=1.
- R9: Codes 15, 16, 17 and 18 set C, clear C, set V and clear V, and change no other flag. Code 19 loads all flags from x_i[3:0], with bit 3 N, bit 2 Z, bit 1 V and bit 0 C. All five codes give r_o=0 and wr_o=0.
- R10: ccr_o = {N,Z,V,C} is cleared by reset. On a rising clock edge with en_i=1 it takes the values on n_o, z_o, v_o and c_o; with en_i=0 it holds.
- R11: Codes 20-31 give r_o=0 and wr_o=0, and the next flags equal the register flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Flag register capture enable |
| op_i | input | 5 | Operation code |
| wide_i | input | 1 | 1 selects 16-bit width, 0 selects 8-bit |
| x_i | input | 16 | Accumulator operand X |
| m_i | input | 16 | Second operand M |
| r_o | output | 16 | Result |
| wr_o | output | 1 | Result is meant to be written back |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| v_o | output | 1 | Next overflow flag |
| c_o | output | 1 | Next carry flag |
| ccr_o | output | 4 | Registered flags {N,Z,V,C} |

## Verification
The bench sweeps every pair of 8-bit operands for add, subtract and compare. It checks the carry and overflow results against a signed and unsigned range test rather than bit equations. This catches a swapped add/subtract carry rule, or an overflow term keyed to the wrong sign bit, at the 0x7F/0x80 and 0xFF/0x00 edges. Every code is run in both widths with upper-byte garbage on X. Each run is repeated under all four settings of the register's C and V. This exposes a rotate that ignores the old carry, an arithmetic right shift that drops the sign bit, or increment, decrement or logic code that disturbs flags it must keep. Separate register cycles show whether the flags are captured with enable low, or are held when they should be taken.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W   = 5;
  localparam int FLAG_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,
    OP_SUB = 5'd1,
    OP_CMP = 5'd2,
    OP_TST = 5'd3,
    OP_INC = 5'd4,
    OP_DEC = 5'd5,
    OP_AND = 5'd6,
    OP_OR  = 5'd7,
    OP_XOR = 5'd8,
    OP_COM = 5'd9,
    OP_ASL = 5'd10,
    OP_ASR = 5'd11,
    OP_LSR = 5'd12,
    OP_ROL = 5'd13,
    OP_ROR = 5'd14,
    OP_SEC = 5'd15,
    OP_CLC = 5'd16,
    OP_SEV = 5'd17,
    OP_CLV = 5'd18,
    OP_TAP = 5'd19
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/acc_alu_rst_sync.sv
module acc_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  alu_op_e        op_i,
  input  logic           wide_i,
  input  logic [W-1:0]   xm_i,
  input  logic [W-1:0]   mm_i,
  input  logic [W-1:0]   mask_i,
  output logic [W-1:0]   r_o,
  output logic           v_o,
  output logic           c_o
);

  logic           sub;
  logic [W-1:0]   opnd_b;
  logic [W-1:0]   raw;
  logic           xs;
  logic           bs;
  logic           rs;

  always_comb begin
    sub    = 1'b0;
    opnd_b = mm_i;
    case (op_i)
      OP_SUB, OP_CMP: sub = 1'b1;
      OP_TST: begin
        sub    = 1'b1;
        opnd_b = '0;
      end
      OP_INC: opnd_b = W'(1);
      OP_DEC: begin
        sub    = 1'b1;
        opnd_b = W'(1);
      end
      default: ;
    endcase
  end

  always_comb begin
    raw = sub ? (xm_i - opnd_b) : (xm_i + opnd_b);
    r_o = raw & mask_i;
    xs  = wide_i ? xm_i[W-1]   : xm_i[NW-1];
    bs  = wide_i ? opnd_b[W-1] : opnd_b[NW-1];
    rs  = wide_i ? r_o[W-1]    : r_o[NW-1];
    if (sub) begin
      v_o = (xs & ~bs & ~rs) | (~xs & bs & rs);
      c_o = (~xs & bs) | (bs & rs) | (rs & ~xs);
    end else begin
      v_o = (xs & bs & ~rs) | (~xs & ~bs & rs);
      c_o = (xs & bs) | (bs & ~rs) | (~rs & xs);
    end
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   xm_i,
  input  logic [W-1:0]   mm_i,
  input  logic [W-1:0]   mask_i,
  output logic [W-1:0]   r_o
);

  always_comb begin
    case (op_i)
      OP_AND:  r_o = xm_i & mm_i;
      OP_OR:   r_o = xm_i | mm_i;
      OP_XOR:  r_o = xm_i ^ mm_i;
      OP_COM:  r_o = ~xm_i & mask_i;
      default: r_o = '0;
    endcase
  end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  alu_op_e        op_i,
  input  logic           wide_i,
  input  logic           cin_i,
  input  logic [W-1:0]   xm_i,
  input  logic [W-1:0]   mask_i,
  output logic [W-1:0]   r_o,
  output logic           c_o
);

  logic [W-1:0] left;
  logic [W-1:0] right;
  logic [W-1:0] top_bit;
  logic         xs;

  always_comb begin
    left    = (xm_i << 1) & mask_i;
    right   = xm_i >> 1;
    top_bit = wide_i ? (W'(1) << (W-1)) : (W'(1) << (NW-1));
    xs      = wide_i ? xm_i[W-1] : xm_i[NW-1];
  end

  always_comb begin
    r_o = '0;
    c_o = 1'b0;
    case (op_i)
      OP_ASL: begin
        r_o = left;
        c_o = xs;
      end
      OP_ASR: begin
        r_o = right | (xs ? top_bit : '0);
        c_o = xm_i[0];
      end
      OP_LSR: begin
        r_o = right;
        c_o = xm_i[0];
      end
      OP_ROL: begin
        r_o = left | W'(cin_i);
        c_o = xs;
      end
      OP_ROR: begin
        r_o = right | (cin_i ? top_bit : '0);
        c_o = xm_i[0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu_flagmux.sv
module acc_alu_flagmux
  import acc_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  alu_op_e        op_i,
  input  logic           wide_i,
  input  logic [W-1:0]   xm_i,
  input  flags_t         cur_i,
  input  logic [W-1:0]   ar_r_i,
  input  logic           ar_v_i,
  input  logic           ar_c_i,
  input  logic [W-1:0]   lg_r_i,
  input  logic [W-1:0]   sh_r_i,
  input  logic           sh_c_i,
  output logic [W-1:0]   r_o,
  output logic           wr_o,
  output flags_t         nxt_o
);

  logic upd_nz;
  logic xs;
  logic shs;

  always_comb begin
    xs  = wide_i ? xm_i[W-1]   : xm_i[NW-1];
    shs = wide_i ? sh_r_i[W-1] : sh_r_i[NW-1];
  end

  always_comb begin
    nxt_o  = cur_i;
    r_o    = '0;
    wr_o   = 1'b0;
    upd_nz = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB, OP_CMP, OP_TST: begin
        r_o     = ar_r_i;
        wr_o    = (op_i == OP_ADD) || (op_i == OP_SUB);
        nxt_o.v = ar_v_i;
        nxt_o.c = ar_c_i;
        upd_nz  = 1'b1;
      end
      OP_INC, OP_DEC: begin
        r_o     = ar_r_i;
        wr_o    = 1'b1;
        nxt_o.z = (ar_r_i == '0);
      end
      OP_AND, OP_OR, OP_XOR, OP_COM: begin
        r_o     = lg_r_i;
        wr_o    = 1'b1;
        nxt_o.v = 1'b0;
        upd_nz  = 1'b1;
      end
      OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
        r_o     = sh_r_i;
        wr_o    = 1'b1;
        nxt_o.c = sh_c_i;
        nxt_o.v = shs ^ xs;
        upd_nz  = 1'b1;
      end
      OP_SEC: nxt_o.c = 1'b1;
      OP_CLC: nxt_o.c = 1'b0;
      OP_SEV: nxt_o.v = 1'b1;
      OP_CLV: nxt_o.v = 1'b0;
      OP_TAP: nxt_o = flags_t'(xm_i[FLAG_W-1:0]);
      default: ;
    endcase
    if (upd_nz) begin
      nxt_o.n = wide_i ? r_o[W-1] : r_o[NW-1];
      nxt_o.z = (r_o == '0);
    end
  end

endmodule

// File: rtl/acc_alu_ccr.sv
module acc_alu_ccr
  import acc_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                en_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic                wide_i,
  input  logic [W-1:0]        x_i,
  input  logic [W-1:0]        m_i,
  output logic [W-1:0]        r_o,
  output logic                wr_o,
  output logic                n_o,
  output logic                z_o,
  output logic                v_o,
  output logic                c_o,
  output logic [FLAG_W-1:0]   ccr_o
);

  logic           rst_sync_n;
  logic [W-1:0]   mask;
  logic [W-1:0]   xm;
  logic [W-1:0]   mm;
  alu_op_e        op;
  flags_t         ccr_q;
  flags_t         ccr_d;
  logic [W-1:0]   ar_r;
  logic           ar_v;
  logic           ar_c;
  logic [W-1:0]   lg_r;
  logic [W-1:0]   sh_r;
  logic           sh_c;

  acc_alu_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_sync_n_o (rst_sync_n)
  );

  generate
    if (W > NW) begin : g_split
      assign mask = wide_i ? {W{1'b1}} : {{(W-NW){1'b0}}, {NW{1'b1}}};
    end else begin : g_flat
      assign mask = {W{1'b1}};
    end
  endgenerate

  always_comb begin
    op = alu_op_e'(op_i);
    xm = x_i & mask;
    mm = m_i & mask;
  end

  acc_alu_arith #(.W(W), .NW(NW)) i_arith (
    .op_i   (op),
    .wide_i (wide_i),
    .xm_i   (xm),
    .mm_i   (mm),
    .mask_i (mask),
    .r_o    (ar_r),
    .v_o    (ar_v),
    .c_o    (ar_c)
  );

  acc_alu_logic #(.W(W)) i_logic (
    .op_i   (op),
    .xm_i   (xm),
    .mm_i   (mm),
    .mask_i (mask),
    .r_o    (lg_r)
  );

  acc_alu_shift #(.W(W), .NW(NW)) i_shift (
    .op_i   (op),
    .wide_i (wide_i),
    .cin_i  (ccr_q.c),
    .xm_i   (xm),
    .mask_i (mask),
    .r_o    (sh_r),
    .c_o    (sh_c)
  );

  acc_alu_flagmux #(.W(W), .NW(NW)) i_flagmux (
    .op_i   (op),
    .wide_i (wide_i),
    .xm_i   (xm),
    .cur_i  (ccr_q),
    .ar_r_i (ar_r),
    .ar_v_i (ar_v),
    .ar_c_i (ar_c),
    .lg_r_i (lg_r),
    .sh_r_i (sh_r),
    .sh_c_i (sh_c),
    .r_o    (r_o),
    .wr_o   (wr_o),
    .nxt_o  (ccr_d)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ccr_q <= '0;
    end else if (en_i) begin
      ccr_q <= ccr_d;
    end
  end

  assign n_o   = ccr_d.n;
  assign z_o   = ccr_d.z;
  assign v_o   = ccr_d.v;
  assign c_o   = ccr_d.c;
  assign ccr_o = ccr_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input logic                clk_i,
  input logic                rst_sync_n,
  input logic                en_i,
  input logic [OP_W-1:0]     op_i,
  input logic                wide_i,
  input logic [W-1:0]        r_o,
  input logic                wr_o,
  input logic                n_o,
  input logic                z_o,
  input logic                v_o,
  input logic                c_o,
  input logic [FLAG_W-1:0]   ccr_o
);

  logic nz_op;
  logic rsign;

  always_comb begin
    nz_op = (op_i <= 5'd3) || ((op_i >= 5'd6) && (op_i <= 5'd14));
    rsign = wide_i ? r_o[W-1] : r_o[NW-1];
  end

  assert_narrow_upper_R1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !wide_i |-> (r_o[W-1:NW] == '0));

  assert_nz_rule_R1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    nz_op |-> ((n_o == rsign) && (z_o == (r_o == '0))));

  assert_no_writeback_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((op_i == OP_CMP) || (op_i == OP_TST)) |-> !wr_o);

  assert_test_clears_vc_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (op_i == OP_TST) |-> (!v_o && !c_o));

  assert_incdec_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((op_i == OP_INC) || (op_i == OP_DEC)) |->
      ((n_o == ccr_o[3]) && (v_o == ccr_o[1]) && (c_o == ccr_o[0])));

  assert_logic_vclear_R6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((op_i >= 5'd6) && (op_i <= 5'd9)) |-> (!v_o && (c_o == ccr_o[0])));

  assert_setcarry_only_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (op_i == OP_SEC) |-> (c_o && (n_o == ccr_o[3]) && (z_o == ccr_o[2]) && (v_o == ccr_o[1]) && !wr_o));

  assert_clrovf_only_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (op_i == OP_CLV) |-> (!v_o && (n_o == ccr_o[3]) && (z_o == ccr_o[2]) && (c_o == ccr_o[0])));

  assert_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    en_i |=> (ccr_o == $past({n_o, z_o, v_o, c_o})));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !en_i |=> $stable(ccr_o));

  assert_undefined_R11: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (op_i > 5'd19) |-> (!wr_o && (r_o == '0) && ({n_o, z_o, v_o, c_o} == ccr_o)));

endmodule

bind acc_alu_ccr acc_alu_chk #(.W(W), .NW(NW)) i_chk (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .en_i       (en_i),
  .op_i       (op_i),
  .wide_i     (wide_i),
  .r_o        (r_o),
  .wr_o       (wr_o),
  .n_o        (n_o),
  .z_o        (z_o),
  .v_o        (v_o),
  .c_o        (c_o),
  .ccr_o      (ccr_o)
);

// File: tb/test_acc_alu_ccr.sv
`timescale 1ns/1ps
module test_acc_alu_ccr;

  logic        clk_i = 1'b0;
  logic        rst_n_i;
  logic        en_i;
  logic [4:0]  op_i;
  logic        wide_i;
  logic [15:0] x_i;
  logic [15:0] m_i;
  logic [15:0] r_o;
  logic        wr_o;
  logic        n_o;
  logic        z_o;
  logic        v_o;
  logic        c_o;
  logic [3:0]  ccr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  acc_alu_ccr i_acc_alu_ccr (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .en_i    (en_i),
    .op_i    (op_i),
    .wide_i  (wide_i),
    .x_i     (x_i),
    .m_i     (m_i),
    .r_o     (r_o),
    .wr_o    (wr_o),
    .n_o     (n_o),
    .z_o     (z_o),
    .v_o     (v_o),
    .c_o     (c_o),
    .ccr_o   (ccr_o)
  );

  // Expected {wr, n, z, v, c, r[15:0]} from ranges and integer arithmetic
  function automatic logic [20:0] model(int op, bit wide, logic [15:0] x, logic [15:0] m, logic [3:0] f);
    int md   = wide ? 65536 : 256;
    int half = md / 2;
    int xv   = int'(x) % md;
    int mv   = int'(m) % md;
    int sx   = (xv >= half) ? xv - md : xv;
    int sm   = (mv >= half) ? mv - md : mv;
    int r    = 0;
    int sr;
    bit wr   = 1'b0;
    bit upd  = 1'b0;
    bit n    = f[3];
    bit z    = f[2];
    bit v    = f[1];
    bit c    = f[0];
    case (op)
      0: begin
        r = (xv + mv) % md; c = (xv + mv) >= md;
        sr = sx + sm; v = (sr >= half) || (sr < -half); wr = 1; upd = 1;
      end
      1, 2: begin
        r = (xv + md - mv) % md; c = xv < mv;
        sr = sx - sm; v = (sr >= half) || (sr < -half); wr = (op == 1); upd = 1;
      end
      3: begin r = xv; c = 0; v = 0; upd = 1; end
      4: begin r = (xv + 1) % md; z = (r == 0); wr = 1; end
      5: begin r = (xv + md - 1) % md; z = (r == 0); wr = 1; end
      6: begin r = xv & mv; v = 0; wr = 1; upd = 1; end
      7: begin r = xv | mv; v = 0; wr = 1; upd = 1; end
      8: begin r = xv ^ mv; v = 0; wr = 1; upd = 1; end
      9: begin r = md - 1 - xv; v = 0; wr = 1; upd = 1; end
      10: begin r = (xv * 2) % md; c = xv >= half; wr = 1; upd = 1; end
      11: begin r = xv / 2 + ((xv >= half) ? half : 0); c = xv[0]; wr = 1; upd = 1; end
      12: begin r = xv / 2; c = xv[0]; wr = 1; upd = 1; end
      13: begin r = (xv * 2) % md + int'(f[0]); c = xv >= half; wr = 1; upd = 1; end
      14: begin r = xv / 2 + (f[0] ? half : 0); c = xv[0]; wr = 1; upd = 1; end
      15: c = 1;
      16: c = 0;
      17: v = 1;
      18: v = 0;
      19: {n, z, v, c} = x[3:0];
      default: ;
    endcase
    if (op >= 10 && op <= 14) v = ((r >= half) != (xv >= half));
    if (upd) begin
      n = r >= half;
      z = r == 0;
    end
    return {wr, n, z, v, c, r[15:0]};
  endfunction

  function automatic string tag(int op);
    if (op == 0) return "R2";
    if (op == 1) return "R3";
    if (op <= 3) return "R4";
    if (op <= 5) return "R5";
    if (op <= 9) return "R6";
    if (op <= 12) return "R7";
    if (op <= 14) return "R8";
    if (op <= 19) return "R9";
    return "R11";
  endfunction

  task automatic check_val(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (op=%0d wide=%0b x=%h m=%h)", req, got, exp, op_i, wide_i, x_i, m_i);
    end
  endtask

  task automatic apply(int op, bit wide, logic [15:0] x, logic [15:0] m);
    logic [20:0] exp;
    op_i = 5'(op); wide_i = wide; x_i = x; m_i = m;
    #1;
    exp = model(op, wide, x, m, ccr_o);
    check_val(tag(op), {11'd0, wr_o, n_o, z_o, v_o, c_o, r_o}, {11'd0, exp});
    if (!wide && x[7:0] == 8'hFF) check_val("R1", {16'd0, r_o[15:8]}, 32'd0);
  endtask

  task automatic set_ccr(logic [3:0] v);
    @(negedge clk_i);
    op_i = 5'd19; wide_i = 1'b0; x_i = {12'hFFF, v}; m_i = '0; en_i = 1'b1;
    @(negedge clk_i);
    en_i = 1'b0;
    check_val("R9", {28'd0, ccr_o}, {28'd0, v});
  endtask

  function automatic logic [15:0] xval(int i, bit wide);
    if (!wide) return {8'hA5, 8'(i)};
    case (i)
      0: return 16'h0000;
      1: return 16'h7FFF;
      2: return 16'h8000;
      3: return 16'hFFFF;
      default: return {8'(i), 8'(i) ^ 8'h3C};
    endcase
  endfunction

  function automatic logic [15:0] mval(int j, bit wide);
    case (j)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return wide ? 16'h7FFF : 16'h5A7F;
      3: return wide ? 16'h8000 : 16'hC380;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles >= 190000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n_i = 1'b0; en_i = 1'b0; op_i = '0; wide_i = 1'b0; x_i = '0; m_i = '0;
    #3;
    check_val("R10 reset", {28'd0, ccr_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_n_i = 1'b1;
    repeat (4) @(negedge clk_i);

    // R10: capture with enable, hold without
    set_ccr(4'h0);
    op_i = 5'd0; wide_i = 1'b0; x_i = 16'h0080; m_i = 16'h0080; en_i = 1'b1;
    @(negedge clk_i);
    en_i = 1'b0;
    check_val("R10 capture", {28'd0, ccr_o}, 32'h7);
    op_i = 5'd6; x_i = 16'h00FF; m_i = 16'h00F0;
    repeat (2) @(negedge clk_i);
    check_val("R10 hold", {28'd0, ccr_o}, 32'h7);

    // R2 R3 R4: exhaustive 8-bit add, subtract and compare
    set_ccr(4'h0);
    for (int op = 0; op < 3; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          apply(op, 1'b0, {8'h3C, 8'(a)}, {8'hC3, 8'(b)});

    // all codes, both widths, under four register flag settings
    for (int k = 0; k < 4; k++) begin
      logic [3:0] fset;
      fset = (k == 0) ? 4'h0 : (k == 1) ? 4'hF : (k == 2) ? 4'h5 : 4'hA;
      set_ccr(fset);
      @(negedge clk_i);
      for (int w = 0; w < 2; w++)
        for (int op = 0; op < 32; op++)
          for (int i = 0; i < 256; i++)
            for (int j = 0; j < 5; j++)
              apply(op, w[0], xval(i, w[0]), mval(j, w[0]));
    end

    finish_run();
  end

endmodule